// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data between memory-mapped locations without processor involvement. It has two independent channels. Each channel is set up with a source address, a destination address, a transfer count, a transfer width and a few mode bits. A one-cycle start pulse latches that setup. The channel is then served by a single master port. Every transfer is one read at the source address, followed by one write of the returned data to the destination address. Each bus phase is held until the memory side answers with a ready signal.

A channel can run as soon as it is started (software trigger), or it can be paced by one peripheral request line that it selects from a small set. When both channels want the bus, the grant goes either to channel 0 always or alternately to the two channels. Each channel chooses how it uses the bus. In cycle-steal mode it gives the bus up after every transfer. In burst mode it keeps the bus until its count is used up. When a channel finishes, it drops its busy state and sets a sticky done flag. The done flag drives that channel's interrupt line when the interrupt is enabled.

Top module: `dma2_top`

## Requirements
- R1: After reset, m_rd, m_wr, ch_busy, ch_done and irq are all low.
- R2: A start pulse with a non-zero count sets that channel's ch_busy on the next clock edge. A start pulse with a count of zero leaves the channel idle, causes no bus activity and leaves ch_done low.
- R3: Each transfer is a read at the current source address followed by a write of exactly the read data to the current destination address. m_rd and m_wr are never high together. m_size carries the width code: 00 for 8 bits, 01 for 16 bits, 10 for 32 bits.
- R4: After each transfer, the source address advances by the transfer width in bytes (1, 2 or 4) when its increment bit is set, and stays unchanged when the bit is clear. The destination address follows its own increment bit in the same way.
- R5: After the programmed number of transfers, ch_busy falls and ch_done rises. ch_done stays high until a ch_done_clr pulse. irq of a channel is high exactly when its ch_done is high and its cfg_irq_en bit is set.
- R6: With prio_rr low, channel 0 is granted whenever both channels request in the same arbitration cycle.
- R7: With prio_rr high, when both channels request, the grant goes to the channel that was not granted last, so back-to-back competing transfers alternate.
- R8: In cycle-steal mode, the cycle after a write completes has neither m_rd nor m_wr high, and arbitration is repeated.
- R9: In burst mode, the next read begins in the cycle right after a write completes. The channel keeps the bus until its count is exhausted, even when the other channel has higher fixed priority.
- R10: With cfg_hw_trig set, a channel starts a transfer only while the peripheral request line chosen by its cfg_req_sel is high. Lines that are not selected have no effect.
- R11: A read or write phase holds its address and data stable for any number of cycles with m_ready low, and ends in the cycle where m_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_rr | input | 1 | 0: channel 0 has fixed priority; 1: round-robin |
| ch_start | input | 2 | Per-channel start pulse; latches the configuration |
| ch_done_clr | input | 2 | Per-channel pulse that clears the done flag |
| cfg_src | input | 2x32 | Start source address per channel |
| cfg_dst | input | 2x32 | Start destination address per channel |
| cfg_count | input | 2x16 | Number of transfers per channel |
| cfg_size | input | 2x2 | Width code per channel (00, 01, 10) |
| cfg_burst | input | 2 | 1: burst, 0: cycle-steal |
| cfg_hw_trig | input | 2 | 1: paced by a peripheral line, 0: software trigger |
| cfg_req_sel | input | 2x2 | Index of the peripheral line to follow |
| cfg_src_inc | input | 2 | Source address increment enable |
| cfg_dst_inc | input | 2 | Destination address increment enable |
| cfg_irq_en | input | 2 | Interrupt enable per channel |
| periph_req | input | 4 | Peripheral request lines |
| m_rd | output | 1 | Read phase active |
| m_wr | output | 1 | Write phase active |
| m_addr | output | 32 | Bus address |
| m_size | output | 2 | Width code of the current transfer |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, taken when m_ready is high in a read phase |
| m_ready | input | 1 | Ends the current phase |
| ch_busy | output | 2 | Channel is running |
| ch_done | output | 2 | Sticky completion flag |
| irq | output | 2 | Completion interrupt |

## Verification
A start pulse sampled at one edge shows as ch_busy right after that edge. The first read phase appears one cycle later, after one arbitration cycle. Every phase then lasts the number of wait cycles the bench memory inserts plus one. The bench drives m_ready and samples m_wr on the falling edge. It pops the expected write from the scoreboard in the same half cycle in which it raises m_ready, so each write is compared in the cycle it completes. Gap checks for cycle-steal and burst look at the falling edge that directly follows a completed write. Busy, done and irq are checked only after the scoreboard has drained and the bus is idle.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int NCH    = 2;
    localparam int NREQ   = 4;
    localparam int SEL_W  = $clog2(NREQ);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  count;
        xfer_size_e        size;
        logic              burst;
        logic              hw_trig;
        logic [SEL_W-1:0]  req_sel;
        logic              src_inc;
        logic              dst_inc;
    } ch_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        xfer_size_e        size;
        logic              burst;
        logic              last;
    } ch_view_t;

    function automatic logic [ADDR_W-1:0] size_step(input xfer_size_e s);
        case (s)
            SZ_BYTE: size_step = ADDR_W'(1);
            SZ_HALF: size_step = ADDR_W'(2);
            default: size_step = ADDR_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/dma2_channel.sv
module dma2_channel
    import dma2_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            done_clr,
    input  ch_cfg_t         cfg,
    input  logic [NREQ-1:0] periph_req,
    input  logic            xfer_ack,
    output logic            req,
    output logic            busy,
    output logic            done,
    output ch_view_t        view
);

    ch_cfg_t          live;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            if (done_clr) begin
                done <= 1'b0;
            end
            if (start && !busy && (cfg.count != '0)) begin
                live <= cfg;
                left <= cfg.count;
                busy <= 1'b1;
            end else if (xfer_ack && busy) begin
                left <= left - CNT_W'(1);
                if (live.src_inc) begin
                    live.src <= live.src + size_step(live.size);
                end
                if (live.dst_inc) begin
                    live.dst <= live.dst + size_step(live.size);
                end
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        req       = busy && (!live.hw_trig || periph_req[live.req_sel]);
        view.src  = live.src;
        view.dst  = live.dst;
        view.size = live.size;
        view.burst = live.burst;
        view.last = (left == CNT_W'(1));
    end

endmodule

// File: rtl/dma2_arbiter.sv
module dma2_arbiter (
    input  logic       rr_mode,
    input  logic [1:0] req,
    input  logic       last_gnt,
    output logic       any,
    output logic       gnt
);

    always_comb begin
        any = |req;
        if (req[0] && req[1]) begin
            gnt = rr_mode ? ~last_gnt : 1'b0;
        end else begin
            gnt = req[1];
        end
    end

endmodule

// File: rtl/dma2_bus_fsm.sv
module dma2_bus_fsm
    import dma2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_mode,
    input  logic [NCH-1:0]    req,
    input  ch_view_t          view [NCH],
    input  logic              m_ready,
    input  logic [DATA_W-1:0] m_rdata,
    output logic [NCH-1:0]    ack,
    output logic              m_rd,
    output logic              m_wr,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata
);

    bus_state_e        state;
    logic              owner;
    logic              last_gnt;
    logic [DATA_W-1:0] data_q;
    logic              arb_any;
    logic              arb_gnt;
    ch_view_t          cur;

    dma2_arbiter u_arb (
        .rr_mode (rr_mode),
        .req     (req),
        .last_gnt(last_gnt),
        .any     (arb_any),
        .gnt     (arb_gnt)
    );

    assign cur = view[owner];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            owner    <= 1'b0;
            last_gnt <= 1'b1;
            data_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arb_any) begin
                        owner    <= arb_gnt;
                        last_gnt <= arb_gnt;
                        state    <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (m_ready) begin
                        data_q <= m_rdata;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (m_ready) begin
                        state <= (cur.burst && !cur.last) ? ST_READ : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        m_rd    = (state == ST_READ);
        m_wr    = (state == ST_WRITE);
        m_size  = cur.size;
        m_wdata = data_q;
        case (state)
            ST_READ:  m_addr = cur.src;
            ST_WRITE: m_addr = cur.dst;
            default:  m_addr = '0;
        endcase
        ack = '0;
        if (state == ST_WRITE && m_ready) begin
            ack[owner] = 1'b1;
        end
    end

endmodule

// File: rtl/dma2_top.sv
module dma2_top
    import dma2_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prio_rr,
    input  logic [NCH-1:0]                ch_start,
    input  logic [NCH-1:0]                ch_done_clr,
    input  logic [NCH-1:0][ADDR_W-1:0]    cfg_src,
    input  logic [NCH-1:0][ADDR_W-1:0]    cfg_dst,
    input  logic [NCH-1:0][CNT_W-1:0]     cfg_count,
    input  logic [NCH-1:0][1:0]           cfg_size,
    input  logic [NCH-1:0]                cfg_burst,
    input  logic [NCH-1:0]                cfg_hw_trig,
    input  logic [NCH-1:0][SEL_W-1:0]     cfg_req_sel,
    input  logic [NCH-1:0]                cfg_src_inc,
    input  logic [NCH-1:0]                cfg_dst_inc,
    input  logic [NCH-1:0]                cfg_irq_en,
    input  logic [NREQ-1:0]               periph_req,
    output logic                          m_rd,
    output logic                          m_wr,
    output logic [ADDR_W-1:0]             m_addr,
    output logic [1:0]                    m_size,
    output logic [DATA_W-1:0]             m_wdata,
    input  logic [DATA_W-1:0]             m_rdata,
    input  logic                          m_ready,
    output logic [NCH-1:0]                ch_busy,
    output logic [NCH-1:0]                ch_done,
    output logic [NCH-1:0]                irq
);

    logic [NCH-1:0] ch_req;
    logic [NCH-1:0] ch_ack;
    ch_view_t       ch_view [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_cfg_t cfg_g;

        always_comb begin
            cfg_g.src     = cfg_src[g];
            cfg_g.dst     = cfg_dst[g];
            cfg_g.count   = cfg_count[g];
            cfg_g.size    = xfer_size_e'(cfg_size[g]);
            cfg_g.burst   = cfg_burst[g];
            cfg_g.hw_trig = cfg_hw_trig[g];
            cfg_g.req_sel = cfg_req_sel[g];
            cfg_g.src_inc = cfg_src_inc[g];
            cfg_g.dst_inc = cfg_dst_inc[g];
        end

        dma2_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .start     (ch_start[g]),
            .done_clr  (ch_done_clr[g]),
            .cfg       (cfg_g),
            .periph_req(periph_req),
            .xfer_ack  (ch_ack[g]),
            .req       (ch_req[g]),
            .busy      (ch_busy[g]),
            .done      (ch_done[g]),
            .view      (ch_view[g])
        );

        assign irq[g] = ch_done[g] & cfg_irq_en[g];
    end

    dma2_bus_fsm u_bus (
        .clk    (clk),
        .rst    (rst),
        .rr_mode(prio_rr),
        .req    (ch_req),
        .view   (ch_view),
        .m_ready(m_ready),
        .m_rdata(m_rdata),
        .ack    (ch_ack),
        .m_rd   (m_rd),
        .m_wr   (m_wr),
        .m_addr (m_addr),
        .m_size (m_size),
        .m_wdata(m_wdata)
    );

endmodule

// File: rtl/dma2_checker.sv
module dma2_checker
    import dma2_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 m_rd,
    input logic                 m_wr,
    input logic                 m_ready,
    input logic [ADDR_W-1:0]    m_addr,
    input logic [DATA_W-1:0]    m_wdata,
    input logic [NCH-1:0]       ch_busy,
    input logic [NCH-1:0]       ch_done,
    input logic [NCH-1:0]       ch_done_clr,
    input logic [NCH-1:0]       irq
);

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(m_rd && m_wr));

    p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (m_rd && m_ready) |=> m_wr);

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (m_rd && !m_ready) |=> (m_rd && $stable(m_addr)));

    p_wr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (m_wr && !m_ready) |=> (m_wr && $stable(m_addr) && $stable(m_wdata)));

    p_bus_needs_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (m_rd || m_wr) |-> (ch_busy != '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_irq_done_r5: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> ch_done[g]);

        p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            $fell(ch_done[g]) |-> $past(ch_done_clr[g]));

        p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_done[g]) |-> !ch_busy[g]);
    end

endmodule

bind dma2_top dma2_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_rd       (m_rd),
    .m_wr       (m_wr),
    .m_ready    (m_ready),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .ch_busy    (ch_busy),
    .ch_done    (ch_done),
    .ch_done_clr(ch_done_clr),
    .irq        (irq)
);

// File: tb/dma2_top_test.sv
module dma2_top_test;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  sz;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prio_rr = 1'b0;
    logic [1:0]        ch_start = '0;
    logic [1:0]        ch_done_clr = '0;
    logic [1:0][31:0]  cfg_src = '0;
    logic [1:0][31:0]  cfg_dst = '0;
    logic [1:0][15:0]  cfg_count = '0;
    logic [1:0][1:0]   cfg_size = '0;
    logic [1:0]        cfg_burst = '0;
    logic [1:0]        cfg_hw_trig = '0;
    logic [1:0][1:0]   cfg_req_sel = '0;
    logic [1:0]        cfg_src_inc = '0;
    logic [1:0]        cfg_dst_inc = '0;
    logic [1:0]        cfg_irq_en = '0;
    logic [3:0]        periph_req = '0;
    logic              m_rd;
    logic              m_wr;
    logic [31:0]       m_addr;
    logic [1:0]        m_size;
    logic [31:0]       m_wdata;
    logic [31:0]       m_rdata = '0;
    logic              m_ready = 1'b0;
    logic [1:0]        ch_busy;
    logic [1:0]        ch_done;
    logic [1:0]        irq;

    int checks = 0;
    int failures = 0;
    int waits = 0;
    int wcnt = 0;
    int gap_mode = 0;
    bit prev_wr_done = 0;
    int cycles = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    dma2_top uut (.*);

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return a ^ 32'hC3C3_0F0F;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model, gap checker and scoreboard monitor, all on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (prev_wr_done) begin
            if (gap_mode == 2)
                check(!m_rd && !m_wr, "R8", "bus idle after write", {30'd0, m_rd, m_wr}, 32'd0);
            else if (gap_mode == 1 && sb.size() > 0)
                check(m_rd, "R9", "read right after write", {31'd0, m_rd}, 32'd1);
        end
        prev_wr_done = 0;
        if (m_rd || m_wr) begin
            if (wcnt >= waits) begin
                m_ready = 1'b1;
                wcnt = 0;
            end else begin
                m_ready = 1'b0;
                wcnt++;
            end
        end else begin
            m_ready = 1'b0;
            wcnt = 0;
        end
        m_rdata = mem_val(m_addr);
        if (m_wr && m_ready) begin
            prev_wr_done = 1;
            if (sb.size() == 0) begin
                check(0, "R3", "unexpected write addr", m_addr, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(m_addr == e.addr, e.tag, "write addr", m_addr, e.addr);
                check(m_wdata == e.data, e.tag, "write data", m_wdata, e.data);
                check(m_size == e.sz, e.tag, "size code", {30'd0, m_size}, {30'd0, e.sz});
            end
        end
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic push(input logic [31:0] a, input logic [31:0] s,
                        input logic [1:0] sz, input string tag);
        exp_t e;
        e.addr = a;
        e.data = mem_val(s);
        e.sz = sz;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] n, input logic [1:0] sz, input bit burst,
                         input bit hw, input logic [1:0] sel, input bit si,
                         input bit di, input bit ien);
        cfg_src[ch] = s;
        cfg_dst[ch] = d;
        cfg_count[ch] = n;
        cfg_size[ch] = sz;
        cfg_burst[ch] = burst;
        cfg_hw_trig[ch] = hw;
        cfg_req_sel[ch] = sel;
        cfg_src_inc[ch] = si;
        cfg_dst_inc[ch] = di;
        cfg_irq_en[ch] = ien;
    endtask

    task automatic kick(input logic [1:0] m);
        @(negedge clk);
        ch_start = m;
        @(negedge clk);
        ch_start = '0;
    endtask

    task automatic clear_done();
        @(negedge clk);
        ch_done_clr = 2'b11;
        @(negedge clk);
        ch_done_clr = 2'b00;
    endtask

    task automatic wait_idle(input string tag);
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (sb.size() == 0 && ch_busy == 2'b00 && !m_rd && !m_wr) begin
                ok = 1;
                break;
            end
        end
        check(ok, tag, "run completes, pending items", sb.size(), 32'd0);
        sb.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!m_rd && !m_wr, "R1", "bus idle in reset", {30'd0, m_rd, m_wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!m_rd && !m_wr, "R1", "bus idle after reset", {30'd0, m_rd, m_wr}, 0);
        check(ch_busy == 0, "R1", "busy after reset", {30'd0, ch_busy}, 0);
        check(ch_done == 0, "R1", "done after reset", {30'd0, ch_done}, 0);
        check(irq == 0, "R1", "irq after reset", {30'd0, irq}, 0);

        // R3 R4 R5 R8: word, cycle-steal, both addresses increment
        gap_mode = 2;
        setup(0, 32'h1000, 32'h2000, 16'd3, 2'b10, 0, 0, 0, 1, 1, 1);
        for (int i = 0; i < 3; i++) push(32'h2000 + 4*i, 32'h1000 + 4*i, 2'b10, "R4");
        @(negedge clk);
        ch_start = 2'b01;
        @(negedge clk);
        ch_start = 2'b00;
        check(ch_busy[0], "R2", "busy after start", {31'd0, ch_busy[0]}, 1);
        wait_idle("R3");
        check(ch_done[0], "R5", "done set", {31'd0, ch_done[0]}, 1);
        check(irq[0], "R5", "irq with enable", {31'd0, irq[0]}, 1);
        repeat (5) @(negedge clk);
        check(ch_done[0], "R5", "done sticky", {31'd0, ch_done[0]}, 1);
        clear_done();
        check(ch_done[0] == 0 && irq[0] == 0, "R5", "done cleared", {30'd0, ch_done[0], irq[0]}, 0);
        gap_mode = 0;

        // R2 zero count does not start
        setup(0, 32'h1000, 32'h2000, 16'd0, 2'b10, 0, 0, 0, 1, 1, 1);
        kick(2'b01);
        check(ch_busy[0] == 0, "R2", "zero count busy", {31'd0, ch_busy[0]}, 0);
        repeat (20) @(negedge clk);
        check(!m_rd && !m_wr, "R2", "zero count no bus", {30'd0, m_rd, m_wr}, 0);
        check(ch_done[0] == 0, "R2", "zero count no done", {31'd0, ch_done[0]}, 0);

        // R9 R11 R4: byte burst, fixed source, wait states
        waits = 2;
        gap_mode = 1;
        setup(0, 32'h3000, 32'h4000, 16'd4, 2'b00, 1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) push(32'h4000 + i, 32'h3000, 2'b00, "R11");
        kick(2'b01);
        wait_idle("R9");
        gap_mode = 0;
        waits = 0;
        clear_done();

        // R4 R5: half width, fixed destination, interrupt disabled
        setup(1, 32'h5000, 32'h6000, 16'd2, 2'b01, 0, 0, 0, 1, 0, 0);
        push(32'h6000, 32'h5000, 2'b01, "R4");
        push(32'h6000, 32'h5002, 2'b01, "R4");
        kick(2'b10);
        wait_idle("R4");
        check(ch_done[1] == 1 && irq[1] == 0, "R5", "done without irq", {30'd0, ch_done[1], irq[1]}, 32'h2);
        clear_done();

        // R6 fixed priority
        prio_rr = 1'b0;
        setup(0, 32'h100, 32'h200, 16'd2, 2'b10, 0, 0, 0, 1, 1, 0);
        setup(1, 32'h300, 32'h400, 16'd2, 2'b10, 0, 0, 0, 1, 1, 0);
        push(32'h200, 32'h100, 2'b10, "R6");
        push(32'h204, 32'h104, 2'b10, "R6");
        push(32'h400, 32'h300, 2'b10, "R6");
        push(32'h404, 32'h304, 2'b10, "R6");
        kick(2'b11);
        wait_idle("R6");
        clear_done();

        // R7 round robin, last grant was channel 1
        prio_rr = 1'b1;
        push(32'h200, 32'h100, 2'b10, "R7");
        push(32'h400, 32'h300, 2'b10, "R7");
        push(32'h204, 32'h104, 2'b10, "R7");
        push(32'h404, 32'h304, 2'b10, "R7");
        kick(2'b11);
        wait_idle("R7");
        prio_rr = 1'b0;
        clear_done();

        // R10 hardware trigger on line 2, line 1 ignored
        setup(1, 32'h700, 32'h800, 16'd2, 2'b10, 0, 1, 2'd2, 1, 1, 0);
        push(32'h800, 32'h700, 2'b10, "R10");
        push(32'h804, 32'h704, 2'b10, "R10");
        periph_req = 4'b0010;
        kick(2'b10);
        repeat (20) @(negedge clk);
        check(sb.size() == 2, "R10", "no transfer without selected line", sb.size(), 2);
        check(ch_busy[1], "R10", "still busy while waiting", {31'd0, ch_busy[1]}, 1);
        periph_req = 4'b0100;
        wait_idle("R10");
        periph_req = 4'b0000;
        clear_done();

        // R9 burst keeps bus against higher priority channel
        waits = 1;
        setup(1, 32'h900, 32'hA00, 16'd3, 2'b10, 1, 0, 0, 1, 1, 0);
        setup(0, 32'hB00, 32'hC00, 16'd2, 2'b10, 0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 3; i++) push(32'hA00 + 4*i, 32'h900 + 4*i, 2'b10, "R9");
        for (int i = 0; i < 2; i++) push(32'hC00 + 4*i, 32'hB00 + 4*i, 2'b10, "R9");
        kick(2'b10);
        while (!m_rd) @(negedge clk);
        kick(2'b01);
        wait_idle("R9");
        waits = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule